// File: doc/BRIEF.md
# Unipolar Stepper Phase Sequencer

This block converts a step clock into the four on/off drive signals for a unipolar two-phase stepping motor. The four signals are the two ends of winding A (`phA`, `phAB`) and the two ends of winding B (`phB`, `phBB`). It runs in a fast system-clock domain. Every control input arrives asynchronously and passes through a two-flop synchronizer. Step-clock edges are detected after synchronization.

A three-bit excitation index moves around eight positions. In half-step mode the index visits every position. In full-step mode it visits only the positions that energize two phases. The excitation mode, the edge sensitivity and the direction can all change while the motor runs, and the index keeps its position when they do. Pulling enable low masks the four drivers. The index keeps counting while masked, so drive resumes in step with the clock it was given.

Three error pulses report timing rule violations. They cover a direction change too close to a rising step edge, a mode change too close to a rising step edge, and two step edges closer together than the minimum pulse width. Each window is a parameter counted in system-clock cycles.

Top module: `stepper_phase_seq`

## Requirements
- R1: With `halfStepIn` high, each qualifying step edge moves the index by one position. The index positions and their drive patterns, written `{phA,phAB,phB,phBB}`, are: 0=1000, 1=1010, 2=0010, 3=0110, 4=0100, 5=0101, 6=0001, 7=1001. The index wraps modulo 8.
- R2: With `halfStepIn` low, the index moves by two positions from an odd (two-phase) position and by one position from an even (single-phase) position. After any full-step advance, the index therefore sits on a two-phase pattern.
- R3: With `risingOnlyIn` high, only rising step-clock edges advance the index. With `risingOnlyIn` low, both rising and falling edges advance it.
- R4: With `dirIn` high, the index increases. With `dirIn` low, it decreases.
- R5: Changing `halfStepIn` or `risingOnlyIn` leaves the index, and so the present drive pattern, unchanged.
- R6: With `enableIn` low, all four outputs are 0 while the index keeps advancing on qualifying edges. After `enableIn` returns high, the outputs show the pattern of the advanced index.
- R7: While `seqResetNIn` is low, the index is held at position 0 (pattern 1000) and step edges are ignored. The first qualifying edge after release moves the index from position 0.
- R8: `phA` and `phAB` are never both 1, and `phB` and `phBB` are never both 1.
- R9: A step-clock level change that meets a system-clock edge k reaches the outputs after edge k+2 and not before.
- R10: `dirWinErr` pulses for one cycle when a synchronized direction change and a synchronized rising step edge are fewer than `DIR_GUARD` cycles apart. It stays low otherwise.
- R11: `modeWinErr` pulses for one cycle when a synchronized change of either mode input and a synchronized rising step edge are fewer than `MODE_GUARD` cycles apart. It stays low otherwise.
- R12: `widthErr` pulses for one cycle when two synchronized step edges of either polarity are fewer than `MIN_WIDTH` cycles apart. The short edge still steps the index.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low system reset |
| stepClkIn | input | 1 | Asynchronous step clock |
| seqResetNIn | input | 1 | Asynchronous active-low sequencer hold to position 0 |
| dirIn | input | 1 | Direction: 1 increases the index, 0 decreases it |
| enableIn | input | 1 | 1 drives the phases, 0 forces them off |
| halfStepIn | input | 1 | 1 selects half-step, 0 selects full-step |
| risingOnlyIn | input | 1 | 1 selects rising edges only, 0 selects both edges |
| phA | output | 1 | Winding A, first end |
| phAB | output | 1 | Winding A, second end |
| phB | output | 1 | Winding B, first end |
| phBB | output | 1 | Winding B, second end |
| dirWinErr | output | 1 | Direction setup/hold violation pulse |
| modeWinErr | output | 1 | Mode setup/hold violation pulse |
| widthErr | output | 1 | Step pulse width violation pulse |

## Verification
The properties check the following on every cycle:
- complementary ends of a winding never overlap;
- masked drive is all zero;
- a half-step advance moves the index by one in the strobed direction;
- a full-step advance always lands on a two-phase position;
- hold forces position 0;
- with no strobe, the index stays where it is.

The remaining behaviour can only be shown by the bench's scenarios, because each depends on a sequence of stimuli:
- continuity across mode and edge-sensitivity changes;
- resumption after a disable with the steps taken while masked;
- the exact two-cycle synchronizer latency;
- each of the three timing-window flags firing on a crafted violation and staying quiet on legal traffic.

// File: rtl/stepper_seq_pkg.sv
package stepper_seq_pkg;
  // Four winding ends, visited in rotation order A, B, AB, BB.
  localparam int COILS = 4;
  localparam int POSITIONS = 2 * COILS;
  localparam int IDX_W = $clog2(POSITIONS);

  typedef logic [IDX_W-1:0] seq_idx_t;

  // Strobes from control to datapath.
  typedef struct packed {
    logic holdInit;  // force index to position 0
    logic advance;   // one qualifying step edge this cycle
    logic forward;   // direction of the advance
    logic halfMode;  // half-step when set, full-step otherwise
    logic driveOn;   // outputs unmasked
  } seq_strobe_t;
endpackage

// File: rtl/stepper_sync.sv
module stepper_sync #(
  parameter int WIDTH  = 1,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] asyncIn,
  output logic [WIDTH-1:0] syncOut
);
  logic [WIDTH-1:0] stageQ [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stageQ[s] <= '0;
        else        stageQ[s] <= asyncIn;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stageQ[s] <= '0;
        else        stageQ[s] <= stageQ[s-1];
      end
    end
  end

  assign syncOut = stageQ[STAGES-1];
endmodule

// File: rtl/stepper_gap_timer.sv
// Counts cycles since the last event, saturating at LIMIT (LIMIT >= 2).
// 'recent' is high when the last event was fewer than LIMIT cycles ago.
module stepper_gap_timer #(
  parameter int LIMIT = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic evt,
  output logic recent
);
  localparam int CW = $clog2(LIMIT + 1);
  localparam logic [CW-1:0] SAT = CW'(LIMIT);

  logic [CW-1:0] gapCnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            gapCnt <= SAT;
    else if (evt)          gapCnt <= CW'(1);
    else if (gapCnt < SAT) gapCnt <= gapCnt + CW'(1);
  end

  assign recent = (gapCnt < SAT);
endmodule

// File: rtl/stepper_seq_ctrl.sv
module stepper_seq_ctrl
  import stepper_seq_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int DIR_GUARD   = 1563,
  parameter int MODE_GUARD  = 1250,
  parameter int MIN_WIDTH   = 2500
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        stepClkIn,
  input  logic        seqResetNIn,
  input  logic        dirIn,
  input  logic        enableIn,
  input  logic        halfStepIn,
  input  logic        risingOnlyIn,
  output seq_strobe_t strobe,
  output logic        dirWinErr,
  output logic        modeWinErr,
  output logic        widthErr
);
  localparam int NUM_IN = 6;

  logic [NUM_IN-1:0] rawIn, syncIn;
  logic stepS, runS, dirS, enS, halfS, riseOnlyS;
  logic stepQ, dirQ, halfQ, riseOnlyQ;
  logic stepRise, stepFall, anyEdge, qualEdge, dirChg, modeChg;
  logic riseDirRecent, dirRecent, riseModeRecent, modeRecent, edgeRecent;

  assign rawIn = {risingOnlyIn, halfStepIn, enableIn, dirIn, seqResetNIn, stepClkIn};

  stepper_sync #(.WIDTH(NUM_IN), .STAGES(SYNC_STAGES)) sync_i (
    .clk(clk), .rst_n(rst_n), .asyncIn(rawIn), .syncOut(syncIn)
  );

  assign {riseOnlyS, halfS, enS, dirS, runS, stepS} = syncIn;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) {stepQ, dirQ, halfQ, riseOnlyQ} <= '0;
    else        {stepQ, dirQ, halfQ, riseOnlyQ} <= {stepS, dirS, halfS, riseOnlyS};
  end

  assign stepRise = stepS & ~stepQ;
  assign stepFall = ~stepS & stepQ;
  assign anyEdge  = stepRise | stepFall;
  assign qualEdge = stepRise | (stepFall & ~riseOnlyS);
  assign dirChg   = dirS ^ dirQ;
  assign modeChg  = (halfS ^ halfQ) | (riseOnlyS ^ riseOnlyQ);

  always_comb begin
    strobe.holdInit = ~runS;
    strobe.advance  = qualEdge;
    strobe.forward  = dirS;
    strobe.halfMode = halfS;
    strobe.driveOn  = enS;
  end

  // Window timers: each remembers how long ago its event happened.
  stepper_gap_timer #(.LIMIT(DIR_GUARD)) riseDirT_i (
    .clk(clk), .rst_n(rst_n), .evt(stepRise), .recent(riseDirRecent));
  stepper_gap_timer #(.LIMIT(DIR_GUARD)) dirT_i (
    .clk(clk), .rst_n(rst_n), .evt(dirChg), .recent(dirRecent));
  stepper_gap_timer #(.LIMIT(MODE_GUARD)) riseModeT_i (
    .clk(clk), .rst_n(rst_n), .evt(stepRise), .recent(riseModeRecent));
  stepper_gap_timer #(.LIMIT(MODE_GUARD)) modeT_i (
    .clk(clk), .rst_n(rst_n), .evt(modeChg), .recent(modeRecent));
  stepper_gap_timer #(.LIMIT(MIN_WIDTH)) edgeT_i (
    .clk(clk), .rst_n(rst_n), .evt(anyEdge), .recent(edgeRecent));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dirWinErr  <= 1'b0;
      modeWinErr <= 1'b0;
      widthErr   <= 1'b0;
    end else begin
      dirWinErr  <= (stepRise & (dirChg | dirRecent)) | (dirChg & riseDirRecent);
      modeWinErr <= (stepRise & (modeChg | modeRecent)) | (modeChg & riseModeRecent);
      widthErr   <= anyEdge & edgeRecent;
    end
  end
endmodule

// File: rtl/stepper_seq_path.sv
module stepper_seq_path
  import stepper_seq_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  seq_strobe_t strobe,
  output seq_idx_t    idxOut,
  output logic        phA,
  output logic        phAB,
  output logic        phB,
  output logic        phBB
);
  seq_idx_t idxQ, stepSize, idxNext;
  logic [COILS-1:0] coilOn;  // rotation order: A, B, AB, BB

  // Full-step from a two-phase (odd) position jumps two; otherwise one.
  always_comb begin
    stepSize = (strobe.halfMode || !idxQ[0]) ? seq_idx_t'(1) : seq_idx_t'(2);
    idxNext  = strobe.forward ? idxQ + stepSize : idxQ - stepSize;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               idxQ <= '0;
    else if (strobe.holdInit) idxQ <= '0;
    else if (strobe.advance)  idxQ <= idxNext;
  end

  // Coil g is centred on position 2g and is on one position either side.
  for (genvar g = 0; g < COILS; g++) begin : g_coil
    localparam seq_idx_t CENTER = seq_idx_t'(2 * g);
    seq_idx_t offs;
    assign offs = idxQ - CENTER;
    assign coilOn[g] = strobe.driveOn &&
      (offs == seq_idx_t'(POSITIONS - 1) || offs == '0 || offs == seq_idx_t'(1));
  end

  assign idxOut = idxQ;
  assign phA  = coilOn[0];
  assign phB  = coilOn[1];
  assign phAB = coilOn[2];
  assign phBB = coilOn[3];
endmodule

// File: rtl/stepper_phase_seq.sv
module stepper_phase_seq
  import stepper_seq_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int DIR_GUARD   = 1563,
  parameter int MODE_GUARD  = 1250,
  parameter int MIN_WIDTH   = 2500
) (
  input  logic clk,
  input  logic rst_n,
  input  logic stepClkIn,
  input  logic seqResetNIn,
  input  logic dirIn,
  input  logic enableIn,
  input  logic halfStepIn,
  input  logic risingOnlyIn,
  output logic phA,
  output logic phAB,
  output logic phB,
  output logic phBB,
  output logic dirWinErr,
  output logic modeWinErr,
  output logic widthErr
);
  seq_strobe_t strobe;
  seq_idx_t    seqIdx;

  stepper_seq_ctrl #(
    .SYNC_STAGES(SYNC_STAGES), .DIR_GUARD(DIR_GUARD),
    .MODE_GUARD(MODE_GUARD), .MIN_WIDTH(MIN_WIDTH)
  ) ctrl_i (
    .clk(clk), .rst_n(rst_n), .stepClkIn(stepClkIn), .seqResetNIn(seqResetNIn),
    .dirIn(dirIn), .enableIn(enableIn), .halfStepIn(halfStepIn),
    .risingOnlyIn(risingOnlyIn), .strobe(strobe),
    .dirWinErr(dirWinErr), .modeWinErr(modeWinErr), .widthErr(widthErr)
  );

  stepper_seq_path path_i (
    .clk(clk), .rst_n(rst_n), .strobe(strobe), .idxOut(seqIdx),
    .phA(phA), .phAB(phAB), .phB(phB), .phBB(phBB)
  );
endmodule

// File: rtl/stepper_phase_seq_chk.sv
module stepper_phase_seq_chk
  import stepper_seq_pkg::*;
(
  input logic        clk,
  input logic        rst_n,
  input logic        phA,
  input logic        phAB,
  input logic        phB,
  input logic        phBB,
  input seq_idx_t    seqIdx,
  input seq_strobe_t strobe
);
  a_r8_no_complementary: assert property (@(posedge clk) disable iff (!rst_n)
    !(phA && phAB) && !(phB && phBB));

  a_r6_masked_off: assert property (@(posedge clk) disable iff (!rst_n)
    !strobe.driveOn |-> {phA, phAB, phB, phBB} == 4'b0000);

  a_r1_drive_count: assert property (@(posedge clk) disable iff (!rst_n)
    strobe.driveOn |-> ($countones({phA, phAB, phB, phBB}) inside {1, 2}));

  a_r4_half_step_one: assert property (@(posedge clk) disable iff (!rst_n)
    strobe.advance && strobe.halfMode && !strobe.holdInit |=>
      seqIdx == ($past(strobe.forward) ? $past(seqIdx) + seq_idx_t'(1)
                                       : $past(seqIdx) - seq_idx_t'(1)));

  a_r2_full_two_phase: assert property (@(posedge clk) disable iff (!rst_n)
    strobe.advance && !strobe.halfMode && !strobe.holdInit |=> seqIdx[0]);

  a_r7_hold_initial: assert property (@(posedge clk) disable iff (!rst_n)
    strobe.holdInit |=> seqIdx == '0);

  a_r5_idle_stable: assert property (@(posedge clk) disable iff (!rst_n)
    !strobe.advance && !strobe.holdInit |=> $stable(seqIdx));
endmodule

bind stepper_phase_seq stepper_phase_seq_chk chk_i (
  .clk(clk), .rst_n(rst_n), .phA(phA), .phAB(phAB), .phB(phB), .phBB(phBB),
  .seqIdx(seqIdx), .strobe(strobe)
);

// File: tb/stepper_phase_seq_tb_top.sv
module stepper_phase_seq_tb_top;
  localparam int HOLD = 16;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst_n = 1'b0, stepIn = 1'b0, runIn = 1'b0, dirIn = 1'b1;
  logic enIn = 1'b1, halfIn = 1'b1, riseOnlyIn = 1'b1;
  logic phA, phAB, phB, phBB, dirWinErr, modeWinErr, widthErr;

  stepper_phase_seq #(.DIR_GUARD(6), .MODE_GUARD(5), .MIN_WIDTH(10)) dut_i (
    .clk(clk), .rst_n(rst_n), .stepClkIn(stepIn), .seqResetNIn(runIn),
    .dirIn(dirIn), .enableIn(enIn), .halfStepIn(halfIn), .risingOnlyIn(riseOnlyIn),
    .phA(phA), .phAB(phAB), .phB(phB), .phBB(phBB),
    .dirWinErr(dirWinErr), .modeWinErr(modeWinErr), .widthErr(widthErr)
  );

  // Reference model
  int modelIdx = 0;

  function automatic logic [3:0] pat_of(int i);
    case (i)
      0: return 4'b1000; 1: return 4'b1010; 2: return 4'b0010; 3: return 4'b0110;
      4: return 4'b0100; 5: return 4'b0101; 6: return 4'b0001; default: return 4'b1001;
    endcase
  endfunction

  function automatic int next_idx(int i, bit fwd, bit half);
    int s;
    s = (half || (i % 2 == 0)) ? 1 : 2;
    return fwd ? (i + s) % 8 : (i + 8 - s) % 8;
  endfunction

  function automatic logic [3:0] model_pat();
    return enIn ? pat_of(modelIdx) : 4'b0000;
  endfunction

  // Scoreboard
  logic [3:0] patQ[$];
  string reqQ[$];
  logic [3:0] popPat;
  string popReq;
  int nMon = 0, nMonFail = 0;
  int dirErrCnt = 0, modeErrCnt = 0, widthErrCnt = 0, overlapCnt = 0;

  always @(negedge clk) begin
    if (rst_n) begin
      if (dirWinErr)  dirErrCnt++;
      if (modeWinErr) modeErrCnt++;
      if (widthErr)   widthErrCnt++;
      if ((phA && phAB) || (phB && phBB)) overlapCnt++;
    end
    if (patQ.size() > 0) begin
      popPat = patQ.pop_front();
      popReq = reqQ.pop_front();
      nMon++;
      if ({phA, phAB, phB, phBB} !== popPat) begin
        nMonFail++;
        $display("FAIL %s: phases=%b expected=%b", popReq, {phA, phAB, phB, phBB}, popPat);
      end
    end
  end

  int nDir = 0, nDirFail = 0, wdFail = 0;
  bit done = 0;

  task automatic check_val(input string req, input int act, input int exp);
    nDir++;
    if (act != exp) begin
      nDirFail++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic expect_pat(input string req);
    @(posedge clk);
    patQ.push_back(model_pat());
    reqQ.push_back(req);
  endtask

  task automatic settle();
    repeat (HOLD) @(posedge clk);
  endtask

  task automatic drive_step(input logic lvl, input string req);
    @(negedge clk);
    stepIn = lvl;
    if (runIn && (lvl || !riseOnlyIn)) modelIdx = next_idx(modelIdx, dirIn, halfIn);
    settle();
    expect_pat(req);
  endtask

  task automatic pulse(input string req);
    drive_step(1'b1, req);
    drive_step(1'b0, req);
  endtask

  task automatic report(input int extra);
    $display("[TB] %0d tests run, %0d failed", nMon + nDir + extra, nMonFail + nDirFail + extra);
  endtask

  initial begin
    int base;
    repeat (5) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    settle();
    expect_pat("R7 reset state A only");
    pulse("R7 edges ignored while held");
    @(negedge clk) runIn = 1'b1;
    settle();
    expect_pat("R7 still A after release");

    // R9 latency, first step from position 0
    @(negedge clk) stepIn = 1'b1;
    @(posedge clk); @(posedge clk); @(negedge clk);
    check_val("R9 unchanged after two edges", {phA, phAB, phB, phBB}, 4'b1000);
    @(posedge clk); @(negedge clk);
    check_val("R9 changed after third edge", {phA, phAB, phB, phBB}, 4'b1010);
    modelIdx = 1;
    settle();
    drive_step(1'b0, "R3 falling edge ignored in rising-only");

    for (int i = 0; i < 8; i++) pulse("R1 R4 half-step forward");
    @(negedge clk) dirIn = 1'b0;
    settle();
    for (int i = 0; i < 5; i++) pulse("R4 half-step reverse");
    if (modelIdx % 2 == 1) pulse("R4 align");

    @(negedge clk) halfIn = 1'b0;
    settle();
    expect_pat("R5 full-step select keeps position");
    for (int i = 0; i < 5; i++) pulse("R2 full-step reverse");
    @(negedge clk) dirIn = 1'b1;
    settle();
    for (int i = 0; i < 3; i++) pulse("R2 R4 full-step forward");

    @(negedge clk) riseOnlyIn = 1'b0;
    settle();
    expect_pat("R5 edge mode change keeps position");
    for (int i = 0; i < 3; i++) pulse("R3 both edges full-step");
    @(negedge clk) halfIn = 1'b1;
    settle();
    expect_pat("R5 half-step select keeps position");
    for (int i = 0; i < 3; i++) pulse("R3 R1 both edges half-step");
    @(negedge clk) riseOnlyIn = 1'b1;
    settle();

    @(negedge clk) enIn = 1'b0;
    settle();
    expect_pat("R6 disabled outputs off");
    for (int i = 0; i < 3; i++) pulse("R6 off while stepping");
    @(negedge clk) enIn = 1'b1;
    settle();
    expect_pat("R6 resumes with continued timing");

    @(negedge clk) runIn = 1'b0;
    modelIdx = 0;
    settle();
    expect_pat("R7 mid-run hold returns to A");
    pulse("R7 held ignores edges");
    @(negedge clk) runIn = 1'b1;
    settle();
    pulse("R7 first step from A");

    settle();
    check_val("R10 no flag on legal traffic", dirErrCnt, 0);
    check_val("R11 no flag on legal traffic", modeErrCnt, 0);
    check_val("R12 no flag on legal traffic", widthErrCnt, 0);
    check_val("R8 no complementary overlap", overlapCnt, 0);

    base = dirErrCnt;
    @(negedge clk) dirIn = ~dirIn;
    repeat (2) @(posedge clk);
    drive_step(1'b1, "R10 step after late direction change");
    check_val("R10 direction window flag", int'(dirErrCnt > base), 1);
    drive_step(1'b0, "R10 recover");

    base = modeErrCnt;
    @(negedge clk) halfIn = 1'b0;
    repeat (2) @(posedge clk);
    drive_step(1'b1, "R11 step after late mode change");
    check_val("R11 mode window flag", int'(modeErrCnt > base), 1);
    drive_step(1'b0, "R11 recover");
    @(negedge clk) halfIn = 1'b1;
    settle();

    base = widthErrCnt;
    @(negedge clk) stepIn = 1'b1;
    modelIdx = next_idx(modelIdx, dirIn, halfIn);
    repeat (3) @(posedge clk);
    @(negedge clk) stepIn = 1'b0;
    settle();
    expect_pat("R12 short pulse still steps");
    check_val("R12 width flag", int'(widthErrCnt > base), 1);
    check_val("R8 no complementary overlap at end", overlapCnt, 0);

    repeat (4) @(posedge clk);
    done = 1;
    report(0);
    $finish;
  end

  initial begin
    for (int c = 0; c < 200000 && !done; c++) @(posedge clk);
    if (!done) begin
      $display("FAIL watchdog: actual=running expected=finished");
      wdFail = 1;
      report(wdFail);
      $finish;
    end
  end
endmodule